// File: doc/BRIEF.md
# Small Transaction Aggregation Buffer

This block gathers short transactions of a single kind, such as read-address requests or write responses, and packs them into one outbound flit. That way a run of small transactions shares one header instead of each carrying its own. Each incoming entry arrives on a valid/ready stream. It carries an opaque payload together with a destination index and a virtual-channel number. All entries in one flit share the same destination and channel, so those two values travel once, in the header.

The block keeps accumulating until one of three things happens, and it closes the flit on whichever comes first:

- the number of held entries reaches a configurable watermark;
- an arriving entry names a different destination or channel;
- a configurable number of cycles has passed since the first entry of the flit was taken.

The flit then leaves as one header beat followed by its entries, one beat per cycle, in arrival order. The input is held off while a flit is being sent, so no entry is dropped or reordered.

The entry width must be at least the header width, which is count width + channel width + destination width (15 bits with the defaults).

Top module: `txn_pack_buf`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high while no entry is offered.
- R2: When the number of held entries reaches the effective watermark, the flit is emitted. The header beat holds the count in bits [4:0], the channel in bits [7:5] and the destination in bits [14:8], with all higher bits zero.
- R3: A watermark of 0, or any watermark above 16, behaves as 16. No flit ever holds more than 16 entries.
- R4: An offered entry whose destination or channel differs from the held entries is not accepted. The held entries are emitted first, and the stalled entry then becomes the first entry of the next flit.
- R5: With timeout value T, a flit that has not reached the watermark has its header on `out_data` in the cycle after the (T+1)-th rising edge following the edge that accepted its first entry. Entries accepted later do not restart this interval.
- R6: A flit is one header beat (`out_hdr` high) followed, on consecutive cycles, by its entries in arrival order. `out_last` is high on the final entry only.
- R7: `in_ready` is low whenever a header beat or a non-final entry beat is on the output.
- R8: The header count lies between 1 and 16 and equals the number of entry beats that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wm | input | CNT_W (5) | Watermark entry count; 0 or above 16 means 16 |
| cfg_timeout | input | TO_W (16) | Accumulation timeout in cycles |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Entry accepted when high together with `in_valid` |
| in_dest | input | DEST_W (7) | Destination index of the entry |
| in_vc | input | VC_W (3) | Virtual channel of the entry |
| in_data | input | ENTRY_W (16) | Entry payload |
| out_valid | output | 1 | Output beat valid |
| out_hdr | output | 1 | Beat is the flit header |
| out_last | output | 1 | Beat is the final entry of the flit |
| out_data | output | ENTRY_W (16) | Header word or entry payload |

## Verification
The bench drives the block with several input patterns, and each one isolates a single close reason:

- **Back-to-back same-target streams under several watermarks (1, 4, 16, 0 and 20).** These show that flits close on the count, and that the out-of-range watermark values are clamped to 16.
- **Streams that switch destination, and then channel, mid-accumulation.** These separate a close caused by a target change from a close caused by the count. They also show that the stalled entry reappears at the head of the next flit.
- **A lone entry.** This pins the exact cycle at which the timeout fires.
- **Entries spaced a few cycles apart.** These tell a timer that runs from the first entry apart from one that restarts on every entry.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  typedef enum logic [0:0] {
    ST_GATHER = 1'b0,
    ST_SEND   = 1'b1
  } tpb_state_e;
endpackage

// File: rtl/tpb_store.sv
module tpb_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/tpb_timer.sv
module tpb_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      elapsed <= '0;
    end else if (run && (elapsed != '1)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expired = (elapsed >= limit);
endmodule

// File: rtl/tpb_ctrl.sv
module tpb_ctrl
  import tpb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  parameter int DEST_W  = 7,
  parameter int VC_W    = 3,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH) + 1,
  localparam int HDR_W  = CNT_W + VC_W + DEST_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cfg_wm,
  input  logic               tmr_expired,
  output logic               tmr_run,
  output logic               tmr_clr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DEST_W-1:0]  in_dest,
  input  logic [VC_W-1:0]    in_vc,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic               rd_en,
  output logic [AW-1:0]      rd_addr,
  output logic               o_valid,
  output logic               o_hdr,
  output logic               o_last,
  output logic [ENTRY_W-1:0] o_hdr_word
);
  tpb_state_e         state;
  logic [CNT_W-1:0]   held_cnt, flit_len, rd_ptr;
  logic [DEST_W-1:0]  held_dest;
  logic [VC_W-1:0]    held_vc;

  logic [CNT_W-1:0]   wm_eff, cnt_inc, cnt_final;
  logic               gathering, holding, target_diff, force_out, take, close_now;
  logic [DEST_W-1:0]  hdr_dest;
  logic [VC_W-1:0]    hdr_vc;

  always_comb begin
    if (cfg_wm == '0 || cfg_wm > CNT_W'(DEPTH)) wm_eff = CNT_W'(DEPTH);
    else                                         wm_eff = cfg_wm;
  end

  assign gathering   = (state == ST_GATHER);
  assign holding     = (held_cnt != '0);
  assign target_diff = holding && ((in_dest != held_dest) || (in_vc != held_vc));
  assign force_out   = holding && (tmr_expired || held_cnt >= wm_eff);
  assign in_ready    = gathering && !force_out && !(in_valid && target_diff);
  assign take        = in_valid && in_ready;
  assign cnt_inc     = held_cnt + 1'b1;
  assign cnt_final   = take ? cnt_inc : held_cnt;
  assign close_now   = gathering &&
                       (force_out || (in_valid && target_diff) || (take && cnt_inc >= wm_eff));
  assign hdr_dest    = holding ? held_dest : in_dest;
  assign hdr_vc      = holding ? held_vc   : in_vc;

  assign tmr_run = gathering && holding;
  assign tmr_clr = !holding;
  assign wr_en   = take;
  assign wr_addr = held_cnt[AW-1:0];
  assign rd_en   = (state == ST_SEND);
  assign rd_addr = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_GATHER;
      held_cnt   <= '0;
      flit_len   <= '0;
      rd_ptr     <= '0;
      held_dest  <= '0;
      held_vc    <= '0;
      o_valid    <= 1'b0;
      o_hdr      <= 1'b0;
      o_last     <= 1'b0;
      o_hdr_word <= '0;
    end else begin
      o_valid <= 1'b0;
      o_hdr   <= 1'b0;
      o_last  <= 1'b0;
      case (state)
        ST_GATHER: begin
          if (take && !holding) begin
            held_dest <= in_dest;
            held_vc   <= in_vc;
          end
          if (close_now) begin
            state      <= ST_SEND;
            flit_len   <= cnt_final;
            held_cnt   <= '0;
            rd_ptr     <= '0;
            o_valid    <= 1'b1;
            o_hdr      <= 1'b1;
            o_hdr_word <= '0;
            o_hdr_word[HDR_W-1:0] <= {hdr_dest, hdr_vc, cnt_final};
          end else if (take) begin
            held_cnt <= cnt_inc;
          end
        end
        ST_SEND: begin
          o_valid <= 1'b1;
          o_last  <= (rd_ptr == flit_len - CNT_W'(1));
          rd_ptr  <= rd_ptr + 1'b1;
          if (rd_ptr == flit_len - CNT_W'(1)) state <= ST_GATHER;
        end
        default: state <= ST_GATHER;
      endcase
    end
  end
endmodule

// File: rtl/txn_pack_buf.sv
module txn_pack_buf #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  parameter int DEST_W  = 7,
  parameter int VC_W    = 3,
  parameter int TO_W    = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cfg_wm,
  input  logic [TO_W-1:0]    cfg_timeout,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DEST_W-1:0]  in_dest,
  input  logic [VC_W-1:0]    in_vc,
  input  logic [ENTRY_W-1:0] in_data,
  output logic               out_valid,
  output logic               out_hdr,
  output logic               out_last,
  output logic [ENTRY_W-1:0] out_data
);
  logic               tmr_expired, tmr_run, tmr_clr;
  logic               wr_en, rd_en;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [ENTRY_W-1:0] rd_q, hdr_word;

  tpb_timer #(.TO_W(TO_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .limit   (cfg_timeout),
    .expired (tmr_expired)
  );

  tpb_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
  );

  tpb_ctrl #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .DEST_W(DEST_W), .VC_W(VC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_wm      (cfg_wm),
    .tmr_expired (tmr_expired),
    .tmr_run     (tmr_run),
    .tmr_clr     (tmr_clr),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_dest     (in_dest),
    .in_vc       (in_vc),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .o_valid     (out_valid),
    .o_hdr       (out_hdr),
    .o_last      (out_last),
    .o_hdr_word  (hdr_word)
  );

  assign out_data = out_hdr ? hdr_word : rd_q;
endmodule

// File: rtl/tpb_chk.sv
module tpb_chk #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_hdr,
  input logic               out_last,
  input logic [ENTRY_W-1:0] out_data
);
  logic [CNT_W-1:0] hdr_len, body_seen;
  logic [CNT_W-1:0] beat_cnt;

  assign beat_cnt = out_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_len   <= '0;
      body_seen <= '0;
    end else if (out_valid && out_hdr) begin
      hdr_len   <= beat_cnt;
      body_seen <= '0;
    end else if (out_valid) begin
      body_seen <= body_seen + 1'b1;
    end
  end

  a_r7_stall_in_flit: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |-> !in_ready);

  a_r8_hdr_cnt_range: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_hdr |-> (beat_cnt >= CNT_W'(1)) && (beat_cnt <= CNT_W'(DEPTH)));

  a_r6_hdr_then_body: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_hdr |=> out_valid && !out_hdr);

  a_r6_body_contig: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |=> out_valid);

  a_r6_gap_after_last: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |=> !out_valid || out_hdr);

  a_r8_len_match: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> (body_seen + 1'b1) == hdr_len);
endmodule

bind txn_pack_buf tpb_chk #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_hdr   (out_hdr),
  .out_last  (out_last),
  .out_data  (out_data)
);

// File: tb/txn_pack_buf_tb.sv
`timescale 1ns/1ps
module txn_pack_buf_tb;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    cfg_wm = 5'd16;
  logic [15:0]   cfg_timeout = 16'd1000;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [6:0]    in_dest = '0;
  logic [2:0]    in_vc = '0;
  logic [EW-1:0] in_data = '0;
  logic          out_valid, out_hdr, out_last;
  logic [EW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int hdr_cyc = 0;
  bit done = 0;

  logic [EW+1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txn_pack_buf u_dut (
    .clk(clk), .rst(rst), .cfg_wm(cfg_wm), .cfg_timeout(cfg_timeout),
    .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_vc(in_vc),
    .in_data(in_data), .out_valid(out_valid), .out_hdr(out_hdr),
    .out_last(out_last), .out_data(out_data)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected flit: header then n entries with payload base+i
  task automatic expect_flit(input logic [6:0] d, input logic [2:0] v,
                             input int n, input logic [EW-1:0] base, input string tag);
    logic [EW-1:0] h;
    h = '0;
    h[14:0] = {d, v, 5'(n)};
    exp_q.push_back({1'b1, 1'b0, h});
    tag_q.push_back({tag, " hdr"});
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b0, (i == n - 1), EW'(base + EW'(i))});
      tag_q.push_back({tag, " entry"});
    end
  endtask

  task automatic send(input logic [6:0] d, input logic [2:0] v, input logic [EW-1:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_dest = d; in_vc = v; in_data = x;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    acc_cyc = cyc;
    in_valid = 1'b0;
  endtask

  task automatic send_run(input logic [6:0] d, input logic [2:0] v,
                          input int n, input logic [EW-1:0] base);
    for (int i = 0; i < n; i++) send(d, v, EW'(base + EW'(i)));
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "drain: expected beats left", exp_q.size(), 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_hdr) hdr_cyc = cyc;
      if (!out_last) check(!in_ready, "R7 ready during flit", in_ready, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected beat", {out_hdr, out_last, out_data}, 0);
      end else begin
        logic [EW+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_hdr, out_last, out_data} == e, t, {out_hdr, out_last, out_data}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2/R6: watermark 4, eight entries -> two flits of 4, in order
    cfg_wm = 5'd4; cfg_timeout = 16'd1000;
    expect_flit(7'd5, 3'd1, 4, 16'h1000, "R2 wm4 first");
    expect_flit(7'd5, 3'd1, 4, 16'h1004, "R2 wm4 second");
    send_run(7'd5, 3'd1, 8, 16'h1000);
    drain();

    // R2: watermark 1 -> each entry its own flit
    cfg_wm = 5'd1;
    for (int i = 0; i < 3; i++) expect_flit(7'd33, 3'd6, 1, EW'(16'h2000 + i), "R2 wm1");
    send_run(7'd33, 3'd6, 3, 16'h2000);
    drain();

    // R3/R8: watermark 16 -> full flit of 16 (count field 5'b10000)
    cfg_wm = 5'd16;
    expect_flit(7'd127, 3'd7, 16, 16'h3000, "R3 wm16 full");
    send_run(7'd127, 3'd7, 16, 16'h3000);
    drain();

    // R3: watermark 0 treated as 16
    cfg_wm = 5'd0;
    expect_flit(7'd1, 3'd0, 16, 16'h4000, "R3 wm0 as16");
    send_run(7'd1, 3'd0, 16, 16'h4000);
    drain();

    // R3/R5: watermark 20 treated as 16; the remaining 2 leave by timeout
    cfg_wm = 5'd20; cfg_timeout = 16'd40;
    expect_flit(7'd2, 3'd3, 16, 16'h5000, "R3 wm20 as16");
    expect_flit(7'd2, 3'd3, 2, 16'h5010, "R5 wm20 tail");
    send_run(7'd2, 3'd3, 18, 16'h5000);
    drain();

    // R4: destination change, then channel change
    cfg_wm = 5'd8; cfg_timeout = 16'd40;
    expect_flit(7'd5, 3'd1, 3, 16'h6000, "R4 dest A");
    expect_flit(7'd6, 3'd1, 2, 16'h6010, "R4 dest B");
    expect_flit(7'd6, 3'd4, 2, 16'h6020, "R4 vc change");
    send_run(7'd5, 3'd1, 3, 16'h6000);
    send_run(7'd6, 3'd1, 2, 16'h6010);
    send_run(7'd6, 3'd4, 2, 16'h6020);
    drain();

    // R5: lone entry, exact timeout cycle
    cfg_wm = 5'd16; cfg_timeout = 16'd20;
    expect_flit(7'd9, 3'd2, 1, 16'h7000, "R5 lone entry");
    send(7'd9, 3'd2, 16'h7000);
    drain();
    check(hdr_cyc - acc_cyc == 21, "R5 timeout header cycle", hdr_cyc - acc_cyc, 21);

    // R5: spaced entries; the timer runs from the first entry only
    cfg_timeout = 16'd10;
    expect_flit(7'd11, 3'd5, 3, 16'h8000, "R5 spaced first");
    expect_flit(7'd11, 3'd5, 1, 16'h8003, "R5 spaced second");
    for (int i = 0; i < 4; i++) begin
      send(7'd11, 3'd5, EW'(16'h8000 + i));
      repeat (3) @(posedge clk);
    end
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule